// File: doc/BRIEF.md
# Five-Level Dual-Carrier PWM Generator

This block produces the gate pattern for a single-phase five-level inverter. The inverter pairs a three-level leg (outer and inner switch) with a two-level leg that toggles only at the fundamental rate. A quarter-wave sine table is walked forward and then backward by a pointer, and a sign bit marks the half-cycle. Together these rebuild a full rectified reference of 72 steps per fundamental period. The reference is scaled by a modulation setting and compared against two triangular carriers. Both carriers come from a single up/down counter: the lower one spans zero to the counter maximum, and the upper one is the same ramp lifted by one full carrier amplitude.

The sign bit is a square pulse at the fundamental rate. It drives the slow leg directly and steers the two comparator results onto the fast leg's outer and inner switches. Three gate signals are formed independently, and each has a complementary output. The pointer advances every time the carrier reaches a turning point, so one fundamental period spans exactly 36 carrier periods. The outputs are registered and follow the carrier and pointer state with a fixed latency of three clocks.

Top module: `fivelevel_pwm_gen`

## Requirements
- R1: While rst is high and on the clock edges it is held, la_up, la_in and lb_hi are 0 and la_up_n, la_in_n and lb_hi_n are 1.
- R2: Each output pair (la_up/la_up_n, la_in/la_in_n, lb_hi/lb_hi_n) is always complementary.
- R3: The carrier count c starts at 0 after reset, rises by one per clock up to MAXC = 2^CAR_W-1, then falls by one per clock to 0, and repeats without holding an endpoint. The lower carrier is c and the upper carrier is c+MAXC.
- R4: The table pointer p advances on every clock where c arrives at 0 or MAXC. It runs 0..18 and back down to 1, then returns to 0 while the sign bit flips, so lb_hi toggles every 36*MAXC clocks.
- R5: The reference is floor(A(p)*mod_amp / 2^MOD_W), where A(p) = floor((round(10000*sin(5p degrees))*2*MAXC + 5000) / 10000).
- R6: In the positive half-cycle (lb_hi=0), la_up = (ref > c) and la_in = (ref > c+MAXC).
- R7: In the negative half-cycle (lb_hi=1), la_up = !(ref > c+MAXC) and la_in = !(ref > c).
- R8: With mod_amp = 0 the output sits at zero volts: la_up=la_in=0 in the positive half-cycle and la_up=la_in=1 in the negative half-cycle.
- R9: Outputs after clock edge k+2 reflect the carrier, pointer and sign state held before edge k (three register stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_amp | input | MOD_W | Modulation amplitude, fraction of 2^MOD_W |
| la_up | output | 1 | Fast leg outer switch gate |
| la_up_n | output | 1 | Complement of la_up |
| la_in | output | 1 | Fast leg inner switch gate |
| la_in_n | output | 1 | Complement of la_in |
| lb_hi | output | 1 | Slow leg gate, high in the negative half-cycle |
| lb_hi_n | output | 1 | Complement of lb_hi, the fundamental square pulse |

## Verification
The bench builds the block with CAR_W=3 (MAXC=7) and MOD_W=8. This makes a whole fundamental period 504 clocks long, so several complete periods, with both half-cycle flips and every table index in both walking directions, fit in a short run. The small carrier also puts the reference level on carrier endpoints often, so the strict comparison at equality is exercised. Full, half and zero modulation phases, each started from a fresh reset, cover both comparator regions and the zero-volt pattern.

// File: rtl/fl_pwm_pkg.sv
package fl_pwm_pkg;

  localparam int QW_PTS    = 19;
  localparam int QW_LAST   = QW_PTS - 1;
  localparam int SIN_SCALE = 10000;

  // sin(5*k degrees) * 10000, rounded, k = 0..18
  localparam int SINE_E4 [QW_PTS] = '{
    0, 872, 1736, 2588, 3420, 4226, 5000, 5736, 6428, 7071,
    7660, 8192, 8660, 9063, 9397, 9659, 9848, 9962, 10000
  };

  typedef enum logic {
    HALF_POS = 1'b0,
    HALF_NEG = 1'b1
  } half_e;

  function automatic int quarter_amp(input int idx, input int fs);
    return (SINE_E4[idx] * fs + SIN_SCALE / 2) / SIN_SCALE;
  endfunction

endpackage

// File: rtl/fl_carrier.sv
module fl_carrier #(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CAR_W-1:0] cnt,
  output logic             step
);
  localparam logic [CAR_W-1:0] MAXC = {CAR_W{1'b1}};

  logic             up;
  logic [CAR_W-1:0] nxt;

  always_comb begin
    nxt  = up ? cnt + 1'b1 : cnt - 1'b1;
    step = (nxt == MAXC) || (nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= nxt;
      if (nxt == MAXC)     up <= 1'b0;
      else if (nxt == '0)  up <= 1'b1;
    end
  end

  AST_CAR_SLOPE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1)); // R3

  AST_CAR_TURN_TOP: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXC) |=> (cnt == MAXC - 1'b1)); // R3

  AST_CAR_TURN_BOT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cnt == '0) |=> (cnt == 1)); // R3

endmodule

// File: rtl/fl_ref_seq.sv
module fl_ref_seq
  import fl_pwm_pkg::*;
#(
  parameter int CAR_W = 8,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CAR_W-1:0] cnt,
  input  logic [MOD_W-1:0] mod_amp,
  output logic [CAR_W:0]   ref_o,
  output logic [CAR_W-1:0] cnt_o,
  output half_e            half_o
);
  localparam int MAXC  = (1 << CAR_W) - 1;
  localparam int FS    = 2 * MAXC;
  localparam int REF_W = CAR_W + 1;
  localparam int PTR_W = $clog2(QW_PTS);
  localparam int PRD_W = REF_W + MOD_W;
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(QW_LAST);

  logic [PTR_W-1:0] ptr;
  logic             p_up;
  half_e            half;

  // quarter-wave ROM, constant contents, registered read
  logic [REF_W-1:0] rom [QW_PTS];
  for (genvar i = 0; i < QW_PTS; i++) begin : g_rom
    assign rom[i] = REF_W'(quarter_amp(i, FS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      p_up <= 1'b1;
      half <= HALF_POS;
    end else if (step) begin
      if (p_up) begin
        if (ptr == PTR_TOP) begin
          ptr  <= ptr - 1'b1;
          p_up <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end else begin
        if (ptr == 1) begin
          ptr  <= '0;
          p_up <= 1'b1;
          half <= (half == HALF_POS) ? HALF_NEG : HALF_POS;
        end else begin
          ptr <= ptr - 1'b1;
        end
      end
    end
  end

  // stage 1: table read
  logic [REF_W-1:0] amp_q;
  logic [CAR_W-1:0] cnt_d1;
  half_e            half_d1;
  always_ff @(posedge clk) begin
    if (rst) begin
      amp_q   <= '0;
      cnt_d1  <= '0;
      half_d1 <= HALF_POS;
    end else begin
      amp_q   <= rom[ptr];
      cnt_d1  <= cnt;
      half_d1 <= half;
    end
  end

  // stage 2: amplitude scaling
  logic [PRD_W-1:0] prod;
  assign prod = PRD_W'(amp_q) * PRD_W'(mod_amp);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_o  <= '0;
      cnt_o  <= '0;
      half_o <= HALF_POS;
    end else begin
      ref_o  <= prod[MOD_W +: REF_W];
      cnt_o  <= cnt_d1;
      half_o <= half_d1;
    end
  end

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ptr <= PTR_TOP); // R4

  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (rst)
    step |=> !$stable(ptr)); // R4

  AST_HALF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$stable(half) |-> (ptr == '0)); // R4

  AST_REF_RANGE: assert property (@(posedge clk) disable iff (rst)
    ref_o <= REF_W'(FS)); // R5

endmodule

// File: rtl/fl_gate_map.sv
module fl_gate_map
  import fl_pwm_pkg::*;
#(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CAR_W:0]   ref_i,
  input  logic [CAR_W-1:0] cnt_i,
  input  half_e            half_i,
  output logic             la_up,
  output logic             la_up_n,
  output logic             la_in,
  output logic             la_in_n,
  output logic             lb_hi,
  output logic             lb_hi_n
);
  localparam int REF_W = CAR_W + 1;
  localparam logic [REF_W-1:0] MAXC = REF_W'((1 << CAR_W) - 1);

  logic [REF_W-1:0] car_lo, car_hi;
  logic             above_lo, above_hi;
  logic             up_d, in_d, neg_d;

  always_comb begin
    car_lo   = REF_W'(cnt_i);
    car_hi   = car_lo + MAXC;
    above_lo = ref_i > car_lo;
    above_hi = ref_i > car_hi;
    neg_d    = (half_i == HALF_NEG);
    if (neg_d) begin
      up_d = !above_hi;
      in_d = !above_lo;
    end else begin
      up_d = above_lo;
      in_d = above_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      la_up   <= 1'b0;
      la_up_n <= 1'b1;
      la_in   <= 1'b0;
      la_in_n <= 1'b1;
      lb_hi   <= 1'b0;
      lb_hi_n <= 1'b1;
    end else begin
      la_up   <= up_d;
      la_up_n <= !up_d;
      la_in   <= in_d;
      la_in_n <= !in_d;
      lb_hi   <= neg_d;
      lb_hi_n <= !neg_d;
    end
  end

  AST_PAIR_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
    (la_up != la_up_n) && (la_in != la_in_n) && (lb_hi != lb_hi_n)); // R2

  AST_INNER_NEEDS_OUTER: assert property (@(posedge clk) disable iff (rst)
    la_in |-> la_up); // R6

  AST_RESET_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (!la_up && !la_in && !lb_hi)); // R1

endmodule

// File: rtl/fivelevel_pwm_gen.sv
module fivelevel_pwm_gen
  import fl_pwm_pkg::*;
#(
  parameter int CAR_W = 8,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MOD_W-1:0] mod_amp,
  output logic             la_up,
  output logic             la_up_n,
  output logic             la_in,
  output logic             la_in_n,
  output logic             lb_hi,
  output logic             lb_hi_n
);
  logic [CAR_W-1:0] cnt, cnt_q;
  logic             step;
  logic [CAR_W:0]   ref_q;
  half_e            half_q;

  fl_carrier #(.CAR_W(CAR_W)) u_car (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt),
    .step (step)
  );

  fl_ref_seq #(.CAR_W(CAR_W), .MOD_W(MOD_W)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .cnt     (cnt),
    .mod_amp (mod_amp),
    .ref_o   (ref_q),
    .cnt_o   (cnt_q),
    .half_o  (half_q)
  );

  fl_gate_map #(.CAR_W(CAR_W)) u_map (
    .clk     (clk),
    .rst     (rst),
    .ref_i   (ref_q),
    .cnt_i   (cnt_q),
    .half_i  (half_q),
    .la_up   (la_up),
    .la_up_n (la_up_n),
    .la_in   (la_in),
    .la_in_n (la_in_n),
    .lb_hi   (lb_hi),
    .lb_hi_n (lb_hi_n)
  );

endmodule

// File: tb/fivelevel_pwm_gen_tb.sv
`timescale 1ns/1ps
module fivelevel_pwm_gen_tb;
  localparam int CAR_W = 3;
  localparam int MOD_W = 8;
  localparam int MAXC  = (1 << CAR_W) - 1;
  localparam int FS    = 2 * MAXC;
  localparam int HALF_CLKS = 36 * MAXC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [MOD_W-1:0] mod_amp = '0;
  logic la_up, la_up_n, la_in, la_in_n, lb_hi, lb_hi_n;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fivelevel_pwm_gen #(.CAR_W(CAR_W), .MOD_W(MOD_W)) u_dut (
    .clk(clk), .rst(rst), .mod_amp(mod_amp),
    .la_up(la_up), .la_up_n(la_up_n), .la_in(la_in), .la_in_n(la_in_n),
    .lb_hi(lb_hi), .lb_hi_n(lb_hi_n)
  );

  // independent model state (R3, R4)
  int  m_c, m_p;
  bit  m_up, m_pup, m_neg;
  bit  run = 1'b0;
  int  edges = 0;
  logic [5:0] exp_q [$];

  function automatic logic [5:0] expect_gates(int c, int p, bit neg, int m);
    int  s, amp, r;
    bit  hi, lo, up, inr;
    s   = $rtoi($sin(p * 5.0 * 3.14159265358979 / 180.0) * 10000.0 + 0.5);
    amp = (s * FS + 5000) / 10000;       // R5
    r   = (amp * m) >> MOD_W;
    hi  = r > c + MAXC;
    lo  = r > c;
    if (!neg) begin up = lo;  inr = hi;  end   // R6
    else      begin up = !hi; inr = !lo; end   // R7
    return {up, !up, inr, !inr, neg, !neg};
  endfunction

  task automatic model_reset();
    m_c = 0; m_up = 1; m_p = 0; m_pup = 1; m_neg = 0;
  endtask

  task automatic model_advance();
    int nxt;
    nxt = m_up ? m_c + 1 : m_c - 1;
    if (nxt == MAXC) m_up = 0;
    else if (nxt == 0) m_up = 1;
    if (nxt == MAXC || nxt == 0) begin
      if (m_pup) begin
        if (m_p == 18) begin m_p = 17; m_pup = 0; end
        else m_p = m_p + 1;
      end else begin
        if (m_p == 1) begin m_p = 0; m_pup = 1; m_neg = !m_neg; end
        else m_p = m_p - 1;
      end
    end
    m_c = nxt;
  endtask

  // driver: pushes expected output for the state held before this edge
  always @(posedge clk) begin
    if (run) begin
      exp_q.push_back(expect_gates(m_c, m_p, m_neg, int'(mod_amp)));
      model_advance();
      edges = edges + 1;
    end
  end

  // monitor: after edge k+2 the outputs reflect item k (R9)
  int  last_tog;
  bit  prev_lb;
  bit  tog_seen;
  always @(negedge clk) begin
    if (run && edges >= 3) begin
      logic [5:0] got, exp_v;
      string tag;
      got   = {la_up, la_up_n, la_in, la_in_n, lb_hi, lb_hi_n};
      exp_v = exp_q.pop_front();
      if (mod_amp == 0) tag = "R8";
      else if (exp_v[1]) tag = "R7 (R3 R5 R9)";
      else tag = "R6 (R3 R5 R9)";
      total++;
      if (got !== exp_v) begin
        bad++;
        $display("FAIL %s edge=%0d got=%b exp=%b", tag, edges, got, exp_v);
      end
      total++;
      if (la_up == la_up_n || la_in == la_in_n || lb_hi == lb_hi_n) begin
        bad++;
        $display("FAIL R2 edge=%0d got=%b exp=complementary pairs", edges, got);
      end
      if (lb_hi != prev_lb) begin
        if (tog_seen) begin
          total++;
          if (edges - last_tog != HALF_CLKS) begin
            bad++;
            $display("FAIL R4 toggle interval got=%0d exp=%0d", edges - last_tog, HALF_CLKS);
          end
        end
        tog_seen = 1;
        last_tog = edges;
      end
      prev_lb = lb_hi;
    end
  end

  task automatic run_phase(input int m, input int cycles);
    @(posedge clk); #1;
    run = 0;
    rst = 1;
    mod_amp = MOD_W'(m);
    repeat (3) @(posedge clk);
    #1;
    total++;
    if ({la_up, la_up_n, la_in, la_in_n, lb_hi, lb_hi_n} !== 6'b010101) begin
      bad++;
      $display("FAIL R1 got=%b exp=%b", {la_up, la_up_n, la_in, la_in_n, lb_hi, lb_hi_n}, 6'b010101);
    end
    exp_q.delete();
    model_reset();
    edges = 0;
    tog_seen = 0;
    prev_lb = 0;
    last_tog = 0;
    rst = 0;
    run = 1;
    repeat (cycles) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run_phase(255, 2 * 72 * MAXC + 40);  // full depth, R6 R7 R4
    run_phase(128, 72 * MAXC + 20);      // half depth
    run_phase(0,   72 * MAXC + 20);      // zero volts, R8
    run_phase(200, 72 * MAXC + 20);
    @(posedge clk); #1;
    run = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule